// File: doc/BRIEF.md
# Bit-Manipulation and Carry-Less Multiply Unit

This execution unit takes two 32-bit operands, a 5-bit rotate immediate and a 5-bit operation code. They arrive together with a one-cycle request strobe. The unit returns a registered 32-bit result and a one-cycle done pulse. Most operations finish in one cycle: scaled address adds, zero counts, population count, byte reversal, byte-wise or-combine, inverted-operand logic, sign and zero extension, signed and unsigned min/max, rotates and single-bit edits.

The three carry-less multiply forms run on a sequential engine that handles one multiplier bit per clock. While that engine is running, any new request is dropped without effect. The upstream issuer therefore has to hold off for the 32 cycles of a multiply.

Top module: `bitx_alu`

## Requirements
- R1: Synchronous active-high reset clears `out_done` and `out_result` to zero. The first cycle after reset shows no done pulse.
- R2: A request for any operation other than codes 26..28 is accepted at the clock edge where `req_valid` is high and no multiply is running. `out_done` is high for exactly the following cycle, with `out_result` valid in that cycle.
- R3: Codes 0, 1 and 2 return `(req_a << 1) + req_b`, `(req_a << 2) + req_b` and `(req_a << 3) + req_b`, each modulo 2^32.
- R4: Code 3 returns the number of leading zero bits of `req_a`. Code 4 returns the number of trailing zero bits. Code 5 returns the number of set bits. Codes 3 and 4 return 32 for a zero operand.
- R5: Code 6 reverses the order of the four bytes of `req_a`. Code 7 makes each result byte 0xFF when the matching byte of `req_a` has any bit set, and 0x00 otherwise.
- R6: Code 8 returns `a & ~b`, code 9 returns `a | ~b` and code 10 returns `~(a ^ b)`.
- R7: Code 11 sign-extends bits 7:0 of `req_a`. Code 12 sign-extends bits 15:0. Code 13 zero-extends bits 15:0.
- R8: Codes 14 and 15 return the signed minimum and signed maximum of `req_a` and `req_b`. Codes 16 and 17 return the unsigned minimum and unsigned maximum.
- R9: Codes 18 and 19 rotate `req_a` left and right by `req_b[4:0]`, ignoring the upper bits of `req_b`. Codes 20 and 21 rotate left and right by `req_imm`.
- R10: With index `req_b[4:0]`, code 22 sets the indexed bit of `req_a`, code 23 clears it and code 24 inverts it. Code 25 returns that bit in result bit 0, with all other result bits zero.
- R11: With P the 64-bit carry-less (GF(2)) product of `req_a` and `req_b`, code 26 returns P[31:0], code 27 returns P[63:32] and code 28 returns P[62:31].
- R12: A multiply accepted at edge k raises `out_done` at edge k+32 and not before. A request presented while the multiply is running produces no done pulse and does not change the multiply result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 5 | Operation code |
| req_a | input | 32 | First operand |
| req_b | input | 32 | Second operand, also the rotate amount and bit index |
| req_imm | input | 5 | Rotate amount for the immediate rotate forms |
| out_done | output | 1 | One-cycle result strobe |
| out_result | output | 32 | Registered result |

## Verification
The hardest case to produce from the ports is a request that lands while the multiply engine is part-way through its 32 steps. That request has to vanish completely: it must not cause an early done pulse, must not corrupt the running product and must not produce a late pulse. The stimulus starts a multiply and then drives a single-cycle request a few cycles later. It checks every cycle up to the expected finishing edge and one cycle beyond it. The multiply operands are chosen so that cross terms cancel and the top product bit lands in the reversed and high slices, which separates the three output variants from one another.

// File: rtl/bitx_pkg.sv
package bitx_pkg;
  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_SH1ADD = 5'd0,  OP_SH2ADD = 5'd1,  OP_SH3ADD = 5'd2,
    OP_CLZ    = 5'd3,  OP_CTZ    = 5'd4,  OP_CPOP   = 5'd5,
    OP_REV8   = 5'd6,  OP_ORCB   = 5'd7,
    OP_ANDN   = 5'd8,  OP_ORN    = 5'd9,  OP_XNOR   = 5'd10,
    OP_SEXTB  = 5'd11, OP_SEXTH  = 5'd12, OP_ZEXTH  = 5'd13,
    OP_MIN    = 5'd14, OP_MAX    = 5'd15, OP_MINU   = 5'd16, OP_MAXU = 5'd17,
    OP_ROL    = 5'd18, OP_ROR    = 5'd19, OP_ROLI   = 5'd20, OP_RORI = 5'd21,
    OP_BSET   = 5'd22, OP_BCLR   = 5'd23, OP_BINV   = 5'd24, OP_BEXT = 5'd25,
    OP_CLMUL  = 5'd26, OP_CLMULH = 5'd27, OP_CLMULR = 5'd28
  } op_e;

  function automatic logic is_clmul(input op_e op);
    return (op == OP_CLMUL) || (op == OP_CLMULH) || (op == OP_CLMULR);
  endfunction
endpackage

// File: rtl/bitx_count.sv
module bitx_count #(
  parameter int W = 32,
  localparam int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  a,
  output logic [CW-1:0] lz,
  output logic [CW-1:0] tz,
  output logic [CW-1:0] pop
);
  always_comb begin
    lz  = CW'(W);
    tz  = CW'(W);
    pop = '0;
    for (int i = 0; i < W; i++) begin
      if (a[i]) lz = CW'(W - 1 - i);
      pop = pop + CW'(a[i]);
    end
    for (int i = W - 1; i >= 0; i--) begin
      if (a[i]) tz = CW'(i);
    end
  end

  // R4: zero operand saturates both zero counts, never exceeds width
  always_comb begin
    a_r4_zero_counts: assert ((a != '0) || (lz == CW'(W) && tz == CW'(W) && pop == '0));
    a_r4_count_range: assert ((lz <= CW'(W)) && (tz <= CW'(W)) && (pop <= CW'(W)));
  end
endmodule

// File: rtl/bitx_unary.sv
module bitx_unary
  import bitx_pkg::*;
#(
  parameter int W = 32,
  localparam int SW = $clog2(W),
  localparam int CW = SW + 1,
  localparam int NB = W / 8
) (
  input  op_e           op,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic [SW-1:0] imm,
  output logic [W-1:0]  y
);
  logic [CW-1:0]  lz, tz, pop;
  logic [W-1:0]   rev, orc, mask;
  logic [SW-1:0]  ramt;
  logic [2*W-1:0] rl_wide, rr_wide;
  logic           rot_imm;

  bitx_count #(.W(W)) u_count (.a(a), .lz(lz), .tz(tz), .pop(pop));

  for (genvar g = 0; g < NB; g++) begin : g_byte
    assign rev[8*g +: 8] = a[W-8-8*g +: 8];
    assign orc[8*g +: 8] = {8{|a[8*g +: 8]}};
  end

  assign rot_imm = (op == OP_ROLI) || (op == OP_RORI);
  assign ramt    = rot_imm ? imm : b[SW-1:0];
  assign rl_wide = {a, a} << ramt;
  assign rr_wide = {a, a} >> ramt;
  assign mask    = {{(W-1){1'b0}}, 1'b1} << b[SW-1:0];

  always_comb begin
    unique case (op)
      OP_SH1ADD: y = (a << 1) + b;
      OP_SH2ADD: y = (a << 2) + b;
      OP_SH3ADD: y = (a << 3) + b;
      OP_CLZ:    y = {{(W-CW){1'b0}}, lz};
      OP_CTZ:    y = {{(W-CW){1'b0}}, tz};
      OP_CPOP:   y = {{(W-CW){1'b0}}, pop};
      OP_REV8:   y = rev;
      OP_ORCB:   y = orc;
      OP_ANDN:   y = a & ~b;
      OP_ORN:    y = a | ~b;
      OP_XNOR:   y = ~(a ^ b);
      OP_SEXTB:  y = {{(W-8){a[7]}}, a[7:0]};
      OP_SEXTH:  y = {{(W-16){a[15]}}, a[15:0]};
      OP_ZEXTH:  y = {{(W-16){1'b0}}, a[15:0]};
      OP_MIN:    y = ($signed(a) < $signed(b)) ? a : b;
      OP_MAX:    y = ($signed(a) < $signed(b)) ? b : a;
      OP_MINU:   y = (a < b) ? a : b;
      OP_MAXU:   y = (a < b) ? b : a;
      OP_ROL, OP_ROLI: y = rl_wide[2*W-1:W];
      OP_ROR, OP_RORI: y = rr_wide[W-1:0];
      OP_BSET:   y = a | mask;
      OP_BCLR:   y = a & ~mask;
      OP_BINV:   y = a ^ mask;
      OP_BEXT:   y = {{(W-1){1'b0}}, |(a & mask)};
      default:   y = '0;
    endcase
  end
endmodule

// File: rtl/bitx_clmul.sv
module bitx_clmul #(
  parameter int W = 32,
  localparam int SW = $clog2(W)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic           busy,
  output logic           fin,
  output logic [2*W-1:0] prod
);
  logic [2*W-1:0] acc, ash;
  logic [W-1:0]   bsh;
  logic [SW-1:0]  step;

  assign prod = bsh[0] ? (acc ^ ash) : acc;
  assign fin  = busy && (step == SW'(W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      step <= '0;
      acc  <= '0;
      ash  <= '0;
      bsh  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      step <= '0;
      acc  <= '0;
      ash  <= {{W{1'b0}}, a};
      bsh  <= b;
    end else if (busy) begin
      acc  <= prod;
      ash  <= ash << 1;
      bsh  <= bsh >> 1;
      step <= step + SW'(1);
      if (fin) busy <= 1'b0;
    end
  end

  a_r12_start_loads: assert property (@(posedge clk) disable iff (rst)
    start |=> (busy && step == '0));
  a_r12_steps_once: assert property (@(posedge clk) disable iff (rst)
    (busy && !fin && !start) |=> (busy && step == $past(step) + SW'(1)));
  a_r12_stops_after_last: assert property (@(posedge clk) disable iff (rst)
    fin |=> !busy);
endmodule

// File: rtl/bitx_alu.sv
module bitx_alu
  import bitx_pkg::*;
#(
  parameter int W = 32,
  localparam int SW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [4:0]    req_op,
  input  logic [W-1:0]  req_a,
  input  logic [W-1:0]  req_b,
  input  logic [SW-1:0] req_imm,
  output logic          out_done,
  output logic [W-1:0]  out_result
);
  op_e            op;
  op_e            cm_kind;
  logic           cm_busy, cm_fin, accept, op_is_cm;
  logic [W-1:0]   quick_y;
  logic [2*W-1:0] cm_prod;
  logic [W-1:0]   cm_y;

  assign op       = op_e'(req_op);
  assign op_is_cm = is_clmul(op);
  assign accept   = req_valid && !cm_busy;

  bitx_unary #(.W(W)) u_unary (
    .op(op), .a(req_a), .b(req_b), .imm(req_imm), .y(quick_y)
  );

  bitx_clmul #(.W(W)) u_clmul (
    .clk(clk), .rst(rst), .start(accept && op_is_cm),
    .a(req_a), .b(req_b), .busy(cm_busy), .fin(cm_fin), .prod(cm_prod)
  );

  always_comb begin
    unique case (cm_kind)
      OP_CLMULH: cm_y = cm_prod[2*W-1:W];
      OP_CLMULR: cm_y = cm_prod[2*W-2:W-1];
      default:   cm_y = cm_prod[W-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_done   <= 1'b0;
      out_result <= '0;
      cm_kind    <= OP_CLMUL;
    end else begin
      out_done <= 1'b0;
      if (accept && !op_is_cm) begin
        out_result <= quick_y;
        out_done   <= 1'b1;
      end else if (cm_fin) begin
        out_result <= cm_y;
        out_done   <= 1'b1;
      end
      if (accept && op_is_cm) cm_kind <= op;
    end
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_done);
  a_r2_single_cycle_done: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !cm_busy && !op_is_cm) |=> out_done);
  a_r12_busy_no_quick_done: assert property (@(posedge clk) disable iff (rst)
    (cm_busy && !cm_fin) |=> !out_done);
endmodule

// File: tb/test_bitx_alu.sv
module test_bitx_alu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [4:0]  req_op = '0;
  logic [31:0] req_a = '0, req_b = '0;
  logic [4:0]  req_imm = '0;
  logic        out_done;
  logic [31:0] out_result;
  int          n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  bitx_alu i_bitx_alu (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_a(req_a), .req_b(req_b), .req_imm(req_imm),
    .out_done(out_done), .out_result(out_result)
  );

  function automatic logic [63:0] clmul_ref(input logic [31:0] x, input logic [31:0] z);
    logic [63:0] r = '0;
    for (int k = 0; k < 63; k++)
      for (int i = 0; i < 32; i++)
        if (k - i >= 0 && k - i < 32) r[k] = r[k] ^ (x[i] & z[k-i]);
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one single-cycle request, checked in the cycle after the accepting edge
  task automatic quick(input string tag, input logic [4:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [4:0] imm, input logic [31:0] exp);
    req_valid = 1'b1; req_op = op; req_a = a; req_b = b; req_imm = imm;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    check({tag, " done"}, {31'd0, out_done}, 32'd1);
    check(tag, out_result, exp);
  endtask

  task automatic t_reset;
    check("R1 done after reset", {31'd0, out_done}, 32'd0);
    check("R1 result after reset", out_result, 32'd0);
  endtask

  task automatic t_shift_add;
    quick("R3 sh1add", 5'd0, 32'h10, 32'h5, 5'd0, 32'h25);
    quick("R3 sh2add", 5'd1, 32'h10, 32'h5, 5'd0, 32'h45);
    quick("R3 sh3add wrap", 5'd2, 32'hFFFF_FFFF, 32'h3, 5'd0, 32'hFFFF_FFFB);
  endtask

  task automatic t_counts;
    quick("R4 clz", 5'd3, 32'h0001_0000, 0, 0, 32'd15);
    quick("R4 ctz", 5'd4, 32'h0001_0000, 0, 0, 32'd16);
    quick("R4 cpop", 5'd5, 32'hF0F0_0001, 0, 0, 32'd9);
    quick("R4 clz zero", 5'd3, 32'h0, 0, 0, 32'd32);
    quick("R4 ctz zero", 5'd4, 32'h0, 0, 0, 32'd32);
    quick("R4 cpop full", 5'd5, 32'hFFFF_FFFF, 0, 0, 32'd32);
  endtask

  task automatic t_bytes;
    quick("R5 rev8", 5'd6, 32'h1122_3344, 0, 0, 32'h4433_2211);
    quick("R5 orcb", 5'd7, 32'h0080_0001, 0, 0, 32'h00FF_00FF);
  endtask

  task automatic t_neg_logic;
    quick("R6 andn", 5'd8, 32'hFF00_FF00, 32'h0F0F_0F0F, 0, 32'hF000_F000);
    quick("R6 orn", 5'd9, 32'h0, 32'hFFFF_0000, 0, 32'h0000_FFFF);
    quick("R6 xnor", 5'd10, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 0, 32'hFFFF_FFFF);
  endtask

  task automatic t_extend;
    quick("R7 sextb", 5'd11, 32'h1234_5680, 0, 0, 32'hFFFF_FF80);
    quick("R7 sexth", 5'd12, 32'h0000_7FFF, 0, 0, 32'h0000_7FFF);
    quick("R7 zexth", 5'd13, 32'hFFFF_8001, 0, 0, 32'h0000_8001);
  endtask

  task automatic t_minmax;
    quick("R8 min", 5'd14, 32'hFFFF_FFFF, 32'h1, 0, 32'hFFFF_FFFF);
    quick("R8 max", 5'd15, 32'hFFFF_FFFF, 32'h1, 0, 32'h1);
    quick("R8 minu", 5'd16, 32'hFFFF_FFFF, 32'h1, 0, 32'h1);
    quick("R8 maxu", 5'd17, 32'hFFFF_FFFF, 32'h1, 0, 32'hFFFF_FFFF);
  endtask

  task automatic t_rotate;
    quick("R9 rol high bits ignored", 5'd18, 32'h8000_0001, 32'h21, 0, 32'h0000_0003);
    quick("R9 ror", 5'd19, 32'h8000_0001, 32'h4, 0, 32'h1800_0000);
    quick("R9 roli", 5'd20, 32'h1234_5678, 32'h3, 5'd8, 32'h3456_7812);
    quick("R9 rori zero", 5'd21, 32'h1234_5678, 32'h7, 5'd0, 32'h1234_5678);
  endtask

  task automatic t_single_bit;
    quick("R10 bset top", 5'd22, 32'h0, 32'h3F, 0, 32'h8000_0000);
    quick("R10 bclr", 5'd23, 32'hFFFF_FFFF, 32'h0, 0, 32'hFFFF_FFFE);
    quick("R10 binv", 5'd24, 32'h10, 32'h4, 0, 32'h0);
    quick("R10 bext one", 5'd25, 32'h10, 32'h4, 0, 32'h1);
    quick("R10 bext zero", 5'd25, 32'h10, 32'h3, 0, 32'h0);
  endtask

  // multiply: done exactly 32 edges after acceptance; optional stray request
  task automatic clmul_run(input string tag, input logic [4:0] op, input logic [31:0] a,
                           input logic [31:0] b, input logic [31:0] exp, input bit stray);
    int early = 0;
    req_valid = 1'b1; req_op = op; req_a = a; req_b = b;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    if (out_done) early++;
    for (int i = 1; i <= 32; i++) begin
      @(posedge clk); @(negedge clk);
      if (stray && i == 5) begin
        req_valid = 1'b1; req_op = 5'd8; req_a = 32'hFFFF_FFFF; req_b = 32'h0;
      end
      if (stray && i == 6) req_valid = 1'b0;
      if (i < 32 && out_done) early++;
      if (i == 32) begin
        check({tag, " R12 done at 32"}, {31'd0, out_done}, 32'd1);
        check({tag, " R11 value"}, out_result, exp);
      end
    end
    check({tag, " R12 no early done"}, early, 32'd0);
    @(posedge clk); @(negedge clk);
    check({tag, " R12 no late done"}, {31'd0, out_done}, 32'd0);
  endtask

  task automatic t_clmul;
    logic [63:0] p;
    clmul_run("clmul cancel", 5'd26, 32'h8000_0001, 32'h8000_0001, 32'h0000_0001, 1'b0);
    clmul_run("clmulh cancel", 5'd27, 32'h8000_0001, 32'h8000_0001, 32'h4000_0000, 1'b0);
    clmul_run("clmulr cancel", 5'd28, 32'h8000_0001, 32'h8000_0001, 32'h8000_0000, 1'b0);
    clmul_run("clmul small", 5'd26, 32'h3, 32'h3, 32'h5, 1'b0);
    p = clmul_ref(32'hDEAD_BEEF, 32'h1357_9BDF);
    clmul_run("clmulh stray", 5'd27, 32'hDEAD_BEEF, 32'h1357_9BDF, p[63:32], 1'b1);
    clmul_run("clmulr stray", 5'd28, 32'hDEAD_BEEF, 32'h1357_9BDF, p[62:31], 1'b1);
    quick("R2 quick after multiply", 5'd6, 32'hAABB_CCDD, 0, 0, 32'hDDCC_BBAA);
  endtask

  initial begin
    #4_000_000;
    n_cmp++; n_bad++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(posedge clk); @(negedge clk);
    t_reset();
    t_shift_add();
    t_counts();
    t_bytes();
    t_neg_logic();
    t_extend();
    t_minmax();
    t_rotate();
    t_single_bit();
    t_clmul();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule